// File: doc/BRIEF.md
# Latched 3-to-8 Active-Low Decoder

This block turns a binary address into a one-cold select word. Each output line has one bit, and the bit whose index matches the address is driven low. A small address register sits in front of the decoder and is controlled by a hold input. While the hold input is low, the register follows the live address. When the hold input goes high, the register keeps the last address it saw with the hold input low. After that, address changes are ignored until the hold input drops again.

Two enables of opposite polarity gate the outputs: one is active low and one is active high. The select word is driven only when both enables are asserted. Otherwise every line is high. The enables act only on the outputs and never touch the held address. The design is synchronous to one clock and the select word is registered, so each output reflects the inputs sampled at the previous clock edge. The address width is a parameter, and the number of lines is two to the power of that width.

Top module: `latched_decoder`

## Requirements
- R1: When both enables are asserted, sel_n_o bit k is low and every other bit is high exactly when the effective address equals k, with addr_i bit 0 as the least significant bit. The value appears one clock after the inputs are sampled.
- R2: In a cycle where hold_en_i is low, the effective address is the live addr_i, and the held address is reloaded with addr_i.
- R3: In the first cycle that hold_en_i is sampled high, the effective address is the addr_i sampled in the last cycle that hold_en_i was low.
- R4: While hold_en_i stays high, changes on addr_i affect neither the held address nor sel_n_o.
- R5: sel_n_o is all ones, one clock later, in any cycle where en_n_i is high or en_i is low.
- R6: Disabling and then re-enabling the outputs while hold_en_i is high leaves the held address unchanged.
- R7: At most one bit of sel_n_o is low at any time.
- R8: A synchronous active-high reset sets sel_n_o to all ones and clears the held address to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Binary address to decode |
| hold_en_i | input | 1 | Low: follow the address; high: freeze the held address |
| en_n_i | input | 1 | Active-low output enable |
| en_i | input | 1 | Active-high output enable |
| sel_n_o | output | 2**ADDR_W | Registered one-cold select lines |

## Verification
The bench builds the block with the default three-bit address, which gives eight lines. At that size every address can be swept under all four enable combinations, with the expected one-cold word computed by shifting a one. The small address space also lets the bench move the live address through every value while the hold input is high and confirm that the frozen select line never moves. It also checks that the held address survives a disable and re-enable, and that a reset followed by an immediate hold selects line zero.

// File: rtl/latched_decoder_pkg.sv
package latched_decoder_pkg;
  // Outputs are live only with the active-low enable low and the active-high enable high
  function automatic logic gate_open(input logic en_n, input logic en);
    return (!en_n) && en;
  endfunction
endpackage

// File: rtl/addr_hold.sv
module addr_hold #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hold_en_i,
  output logic [ADDR_W-1:0] eff_addr_o
);
  logic [ADDR_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) held_q <= '0;
    else if (!hold_en_i) held_q <= addr_i;
  end

  assign eff_addr_o = hold_en_i ? held_q : addr_i;

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    hold_en_i |=> $stable(held_q));
  // R2
  follow_load_chk: assert property (@(posedge clk) disable iff (rst)
    !hold_en_i |=> held_q == $past(addr_i));
endmodule

// File: rtl/onehot_dec.sv
module onehot_dec #(
  parameter int ADDR_W = 3,
  localparam int OUT_W = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [OUT_W-1:0]  hot_o
);
  for (genvar k = 0; k < OUT_W; k++) begin : g_line
    assign hot_o[k] = (addr_i == ADDR_W'(k));
  end
endmodule

// File: rtl/sel_gate.sv
module sel_gate
  import latched_decoder_pkg::*;
#(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OUT_W-1:0] hot_i,
  input  logic             en_n_i,
  input  logic             en_i,
  output logic [OUT_W-1:0] sel_n_o
);
  logic [OUT_W-1:0] sel_n_q;

  always_ff @(posedge clk) begin
    if (rst) sel_n_q <= '1;
    else if (gate_open(en_n_i, en_i)) sel_n_q <= ~hot_i;
    else sel_n_q <= '1;
  end

  assign sel_n_o = sel_n_q;

  // R5
  closed_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (en_n_i || !en_i) |=> (&sel_n_o));
endmodule

// File: rtl/latched_decoder.sv
module latched_decoder #(
  parameter int ADDR_W = 3,
  localparam int OUT_W = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hold_en_i,
  input  logic              en_n_i,
  input  logic              en_i,
  output logic [OUT_W-1:0]  sel_n_o
);
  logic [ADDR_W-1:0] eff_addr;
  logic [OUT_W-1:0]  hot;

  addr_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst(rst), .addr_i(addr_i), .hold_en_i(hold_en_i),
    .eff_addr_o(eff_addr)
  );

  onehot_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(eff_addr), .hot_o(hot)
  );

  sel_gate #(.OUT_W(OUT_W)) u_gate (
    .clk(clk), .rst(rst), .hot_i(hot), .en_n_i(en_n_i), .en_i(en_i),
    .sel_n_o(sel_n_o)
  );

  // R7
  one_cold_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~sel_n_o) <= 1);
  // R1
  live_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n_i && en_i && !hold_en_i) |=> sel_n_o == ~(OUT_W'(1) << $past(addr_i)));
endmodule

// File: tb/latched_decoder_tb.sv
module latched_decoder_tb;
  localparam int ADDR_W = 3;
  localparam int OUT_W = 1 << ADDR_W;

  logic clk = 0;
  logic rst = 1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic hold_en_i = 0;
  logic en_n_i = 0;
  logic en_i = 1;
  logic [OUT_W-1:0] sel_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [ADDR_W-1:0] held_m = '0;

  always #5 clk = ~clk;

  latched_decoder #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .hold_en_i(hold_en_i),
    .en_n_i(en_n_i), .en_i(en_i), .sel_n_o(sel_n_o)
  );

  task automatic check(input string tag, input logic [OUT_W-1:0] exp);
    checks++;
    if (sel_n_o !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, sel_n_o, exp);
    end
  endtask

  // Drive one cycle of inputs, then check the registered result
  task automatic step(input string tag, input logic [ADDR_W-1:0] a,
                      input logic h, input logic en_n, input logic en);
    logic [ADDR_W-1:0] eff;
    logic [OUT_W-1:0] exp;
    @(negedge clk);
    addr_i = a; hold_en_i = h; en_n_i = en_n; en_i = en;
    eff = h ? held_m : a;
    exp = (!en_n && en) ? ~(OUT_W'(1) << eff) : '1;
    if (!h) held_m = a;
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset outputs high", '1);
    rst = 0;
    held_m = '0;
    // R8: held address cleared, so an immediate hold selects line 0
    step("R8 held zero", 3'd5, 1'b1, 1'b0, 1'b1);
    // R1 R2 R5: every address under every enable combination
    for (int c = 0; c < 4; c++) begin
      for (int a = 0; a < OUT_W; a++) begin
        step((c == 1) ? "R1 R2 decode" : "R5 gated", ADDR_W'(a), 1'b0, c[1], c[0]);
      end
    end
    // R3: capture of the value before the hold edge
    step("R2 load 3", 3'd3, 1'b0, 1'b0, 1'b1);
    step("R3 capture", 3'd5, 1'b1, 1'b0, 1'b1);
    // R4: address sweep while holding
    for (int a = 0; a < OUT_W; a++) begin
      step("R4 hold ignores addr", ADDR_W'(a), 1'b1, 1'b0, 1'b1);
    end
    // R6: disable and re-enable while holding
    step("R6 disabled", 3'd1, 1'b1, 1'b1, 1'b1);
    step("R6 disabled", 3'd2, 1'b1, 1'b0, 1'b0);
    step("R6 reenabled", 3'd7, 1'b1, 1'b0, 1'b1);
    // R2: release follows live address again
    step("R2 release", 3'd6, 1'b0, 1'b0, 1'b1);
    step("R3 capture 6", 3'd0, 1'b1, 1'b0, 1'b1);
    // R7: output never has more than one low bit in the checked samples
    checks++;
    if ($countones(~sel_n_o) > 1) begin
      errors++;
      $display("FAIL R7: got %b expected at most one low", sel_n_o);
    end
    // R8: reset mid-run
    @(negedge clk); rst = 1; hold_en_i = 1;
    @(negedge clk); check("R8 reset mid-run", '1);
    rst = 0; held_m = '0;
    step("R8 held cleared", 3'd4, 1'b1, 1'b0, 1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule